// File: doc/BRIEF.md
# Collision-Vector Pipeline Initiation Controller

This block decides, on every clock cycle, whether a new task may enter a shared nonlinear pipeline. Several tasks can overlap in such a pipeline. Each task uses the stages in a fixed pattern, so some spacings between two starts would make two tasks need the same stage in the same cycle. The forbidden spacings are held in a loadable collision vector. A shift-register state records which future spacings are still blocked by all tasks already in flight. A request is granted in the same cycle it is raised, provided the state allows a start at the current spacing.

Starts are granted greedily. Whenever a request is present and the current spacing is permitted, the start is taken, so under constant demand each task follows the previous one at the smallest permitted latency. The controller also reports its state vector and the number of cycles since the last granted start. The datapath stages are outside this block, and so is any search for an optimal latency cycle.

Top module: `pipe_init_ctrl`

## Requirements
- R1: While reset is applied, and until it has been released synchronously, `start_gnt` is 0, `state_vec` is all zeros and `since_last` is 0, even if `start_req` is 1.
- R2: Bit i-1 of `cv_in` (and of the stored vector) marks latency i as forbidden when it is 1 and as permitted when it is 0. The vector is EVAL_LEN-1 bits wide. The stored vector resets to all zeros.
- R3: No start is granted at a distance d (1 ≤ d ≤ EVAL_LEN-1) after an earlier granted start whose collision vector had bit d-1 set.
- R4: `start_gnt` is 1 in exactly those cycles where `start_req` is 1 and bit 0 of `state_vec` is 0. This yields the greedy policy: each start is taken at the smallest permitted latency.
- R5: In a cycle with no grant, `state_vec` shifts right by one on the next edge and a zero enters at the top. On a grant, the next value is the shifted state ORed with the collision vector in use.
- R6: `since_last` is 0 until the first grant after reset. It is 1 in the cycle after a grant, then counts up by one each cycle, and saturates at EVAL_LEN.
- R7: The first request after reset is granted at once. Any request at a latency of EVAL_LEN or more is granted, and the state after that grant equals the collision vector.
- R8: A `cv_load` pulse is taken only when `state_vec` is all zeros. A load attempted at any other time is ignored: the stored vector does not change.
- R9: If a load is accepted in the same cycle as a grant, that grant already uses the newly loaded vector.
- R10: With vector 1011010 (EVAL_LEN = 8) and a constant request, the latencies between successive grants repeat the cycle 1, 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cv_load | input | 1 | Request to replace the stored collision vector |
| cv_in | input | EVAL_LEN-1 | New collision vector; bit i-1 set forbids latency i |
| start_req | input | 1 | Asks to start a task in this cycle |
| start_gnt | output | 1 | The start is accepted in this cycle |
| state_vec | output | EVAL_LEN-1 | Current state; bit 0 set blocks a start in this cycle |
| since_last | output | $clog2(EVAL_LEN+1) | Cycles since the last grant, saturating at EVAL_LEN; 0 before any grant |

## Verification
The hardest situation to reach from the ports is a vector load that arrives while tasks are still in flight. Its effect stays hidden until the pipeline drains and the next start exposes the stored vector. The bench therefore attempts loads right after grants, waits until the state has decayed to zero, and then compares the state loaded by the next start against the vector that should have survived. A long random phase mixes sparse and dense requests with load attempts at arbitrary moments. Every grant is checked against the full history of earlier starts, so overlapping forbidden latencies from several tasks in flight are covered. Directed runs cover the idle start at a long latency, a load and a start in the same cycle, and the 1, 8 greedy cycle.

// File: rtl/initctl_pkg.sv
package initctl_pkg;
  // Default evaluation time of the reservation table (columns).
  parameter int unsigned DEF_EVAL_LEN = 8;

  // Width of a saturating counter that must reach the given limit.
  function automatic int unsigned cnt_width(input int unsigned limit);
    return $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/initctl_rst_sync.sv
module initctl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/initctl_cv_store.sv
module initctl_cv_store #(
  parameter int unsigned VW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          idle,
  input  logic [VW-1:0] cv_in,
  output logic [VW-1:0] cv_q,
  output logic [VW-1:0] cv_eff
);
  logic          take;
  logic [VW-1:0] cv_d;

  always_comb begin
    take   = load & idle;
    cv_eff = take ? cv_in : cv_q;
    cv_d   = cv_q;
    if (take) cv_d = cv_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cv_q <= '0;
    else if (take) cv_q <= cv_d;
  end

  assert_load_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !idle) |=> $stable(cv_q));
  assert_load_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (load && idle) |=> (cv_q == $past(cv_in)));
endmodule

// File: rtl/initctl_state_reg.sv
module initctl_state_reg #(
  parameter int unsigned VW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [VW-1:0] cv_eff,
  output logic [VW-1:0] st_q
);
  logic [VW-1:0] st_d;

  always_comb begin
    st_d = st_q >> 1;
    if (start) st_d = (st_q >> 1) | cv_eff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assert_shift_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (st_q == ($past(st_q) >> 1)));
  assert_merge_cv_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> ((st_q & $past(cv_eff)) == $past(cv_eff)));
endmodule

// File: rtl/initctl_lat_cnt.sv
module initctl_lat_cnt #(
  parameter int unsigned LIMIT = 8,
  parameter int unsigned LW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic [LW-1:0] cnt_q
);
  localparam logic [LW-1:0] MAXV = LW'(LIMIT);

  logic          en;
  logic [LW-1:0] cnt_d;
  logic          seen_q;

  always_comb begin
    en    = start | (seen_q & (cnt_q != MAXV));
    cnt_d = start ? LW'(1) : cnt_q + LW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      if (en)    cnt_q  <= cnt_d;
      if (start) seen_q <= 1'b1;
    end
  end

  assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt_q == LW'(1)));
  assert_saturate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && cnt_q == MAXV) |=> (cnt_q == MAXV));
  assert_no_start_yet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && cnt_q == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/pipe_init_ctrl.sv
module pipe_init_ctrl #(
  parameter int unsigned EVAL_LEN = initctl_pkg::DEF_EVAL_LEN,
  localparam int unsigned VW = EVAL_LEN - 1,
  localparam int unsigned LW = initctl_pkg::cnt_width(EVAL_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cv_load,
  input  logic [VW-1:0] cv_in,
  input  logic          start_req,
  output logic          start_gnt,
  output logic [VW-1:0] state_vec,
  output logic [LW-1:0] since_last
);
  logic          rst_i;
  logic [VW-1:0] st_q;
  logic [VW-1:0] cv_q;
  logic [VW-1:0] cv_eff;
  logic          idle;
  logic          gnt;

  initctl_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_i)
  );

  assign idle = ~|st_q;
  assign gnt  = start_req & ~st_q[0] & rst_i;

  initctl_cv_store #(.VW(VW)) u_cv (
    .clk    (clk),
    .rst_n  (rst_i),
    .load   (cv_load),
    .idle   (idle),
    .cv_in  (cv_in),
    .cv_q   (cv_q),
    .cv_eff (cv_eff)
  );

  initctl_state_reg #(.VW(VW)) u_state (
    .clk    (clk),
    .rst_n  (rst_i),
    .start  (gnt),
    .cv_eff (cv_eff),
    .st_q   (st_q)
  );

  initctl_lat_cnt #(.LIMIT(EVAL_LEN), .LW(LW)) u_lat (
    .clk   (clk),
    .rst_n (rst_i),
    .start (gnt),
    .cnt_q (since_last)
  );

  assign start_gnt = gnt;
  assign state_vec = st_q;

  assert_idle_grant_R7: assert property (@(posedge clk) disable iff (!rst_i)
    (start_req && idle) |-> start_gnt);
  assert_long_gap_R7: assert property (@(posedge clk) disable iff (!rst_i)
    (since_last == LW'(EVAL_LEN)) |-> idle);
  assert_blocked_R3: assert property (@(posedge clk) disable iff (!rst_i)
    state_vec[0] |-> !start_gnt);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_i |-> (!start_gnt && idle && since_last == '0));
  assert_vec_used_R2: assert property (@(posedge clk) disable iff (!rst_i)
    (start_gnt && !cv_load) |=> ((state_vec & cv_q) == cv_q));
endmodule

// File: tb/tb_pipe_init_ctrl.sv
module tb_pipe_init_ctrl;
  localparam int unsigned N  = 8;
  localparam int unsigned VW = N - 1;
  localparam int unsigned LW = $clog2(N + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cv_load;
  logic [VW-1:0] cv_in;
  logic          start_req;
  logic          start_gnt;
  logic [VW-1:0] state_vec;
  logic [LW-1:0] since_last;

  pipe_init_ctrl #(.EVAL_LEN(N)) dut (
    .clk(clk), .rst_n(rst_n), .cv_load(cv_load), .cv_in(cv_in),
    .start_req(start_req), .start_gnt(start_gnt),
    .state_vec(state_vec), .since_last(since_last)
  );

  always #10 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // bench model: history of grants indexed by model cycle
  bit            hist_g [64];
  logic [VW-1:0] hist_cv[64];
  logic [VW-1:0] cv_model;
  int            t_now;
  int            last_g;
  bit            cap_on;
  int            cap_n;
  int            cap_t[16];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // state bit k: is a start at t_now+k forbidden by some earlier start?
  function automatic logic [VW-1:0] exp_state();
    logic [VW-1:0] s = '0;
    for (int d = 1; d <= int'(VW); d++) begin
      int g = t_now - d;
      if (g >= 0 && hist_g[g % 64]) begin
        for (int k = 0; k < int'(VW); k++) begin
          int idx = d + k - 1;
          if (idx < int'(VW) && hist_cv[g % 64][idx]) s[k] = 1'b1;
        end
      end
    end
    return s;
  endfunction

  function automatic int exp_since();
    if (last_g < 0) return 0;
    if (t_now - last_g >= int'(N)) return int'(N);
    return t_now - last_g;
  endfunction

  task automatic step(input logic r, input logic ld, input logic [VW-1:0] c);
    logic [VW-1:0] st_e;
    logic [VW-1:0] use_cv;
    logic          g_e;
    bit            acc;
    @(negedge clk);
    start_req = r; cv_load = ld; cv_in = c;
    #5;
    st_e   = exp_state();
    acc    = ld && (st_e == '0);
    use_cv = acc ? c : cv_model;
    g_e    = r && !st_e[0];
    chk(start_gnt == g_e, "R4 grant", start_gnt, g_e);
    chk(state_vec == st_e, "R5 state", state_vec, st_e);
    chk(since_last == LW'(exp_since()), "R6 since_last", since_last, exp_since());
    if (start_gnt) begin
      for (int d = 1; d <= int'(VW); d++) begin
        int g = t_now - d;
        if (g >= 0 && hist_g[g % 64] && hist_cv[g % 64][d-1])
          chk(1'b0, "R3 collision", d, 0);
      end
    end
    hist_g[t_now % 64]  = g_e;
    hist_cv[t_now % 64] = use_cv;
    if (acc) cv_model = c;
    if (g_e) begin
      last_g = t_now;
      if (cap_on && cap_n < 16) begin cap_t[cap_n] = t_now; cap_n++; end
    end
    t_now++;
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
  endtask

  localparam logic [VW-1:0] CV_A = 7'b1011010;
  localparam logic [VW-1:0] CV_B = 7'b0100101;

  initial begin
    #(200000 * 20);
    if (!finished) begin
      chk(1'b0, "watchdog", 0, 1);
      report();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 64; i++) begin hist_g[i] = 1'b0; hist_cv[i] = '0; end
    cv_model = '0; t_now = 0; last_g = -1; cap_on = 1'b0; cap_n = 0;
    rst_n = 1'b0; start_req = 1'b1; cv_load = 1'b0; cv_in = '0;
    // R1: quiet outputs while in reset, even with a request
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #5;
      chk(start_gnt == 1'b0, "R1 gnt", start_gnt, 0);
      chk(state_vec == '0, "R1 state", state_vec, 0);
      chk(since_last == '0, "R1 since_last", since_last, 0);
    end
    @(negedge clk); rst_n = 1'b1; start_req = 1'b0;
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, '0);

    // R2/R10: load the example vector and request on every cycle
    step(1'b0, 1'b1, CV_A);
    cap_on = 1'b1;
    step(1'b1, 1'b0, '0);
    chk(start_gnt == 1'b1, "R7 first request granted", start_gnt, 1);
    for (int i = 0; i < 39; i++) step(1'b1, 1'b0, '0);
    cap_on = 1'b0;
    chk(cap_n >= 8, "R10 grant count", cap_n, 8);
    for (int i = 0; i + 1 < cap_n; i++)
      chk(cap_t[i+1] - cap_t[i] == ((i % 2 == 0) ? 1 : 8), "R10 latency cycle",
          cap_t[i+1] - cap_t[i], (i % 2 == 0) ? 1 : 8);

    // R8: load while busy is ignored
    for (int i = 0; i < 8; i++) step(1'b0, 1'b0, '0);
    step(1'b1, 1'b0, '0);
    step(1'b0, 1'b1, 7'b0000001);
    chk(state_vec != '0, "R8 busy at load", state_vec, 1);
    for (int i = 0; i < 10; i++) step(1'b0, 1'b0, '0);
    chk(since_last == LW'(N), "R6 saturation", since_last, N);
    step(1'b1, 1'b0, '0);
    chk(start_gnt == 1'b1, "R7 long latency granted", start_gnt, 1);
    step(1'b0, 1'b0, '0);
    chk(state_vec == CV_A, "R8 old vector kept", state_vec, CV_A);

    // R9: load and start in the same idle cycle
    for (int i = 0; i < 8; i++) step(1'b0, 1'b0, '0);
    step(1'b1, 1'b1, CV_B);
    chk(start_gnt == 1'b1, "R9 grant", start_gnt, 1);
    step(1'b0, 1'b0, '0);
    chk(state_vec == CV_B, "R9 new vector used", state_vec, CV_B);
    // R3: dense requests under the second vector
    for (int i = 0; i < 30; i++) step(1'b1, 1'b0, '0);

    // random phase: mixed request density and load attempts
    for (int i = 0; i < 1500; i++) begin
      logic r  = (($urandom % 100) < ((i / 300) % 2 == 0 ? 70 : 25));
      logic ld = (($urandom % 100) < 8);
      logic [VW-1:0] c = VW'($urandom);
      step(r, ld, c);
    end

    finished = 1'b1;
    report();
    $finish;
  end
endmodule